// File: doc/BRIEF.md
# Valid-Gated Elastic Register File

This block is a small register file meant to sit inside a latency-insensitive pipeline in which every channel carries a valid signal forward and a stop signal backward. For flow-control purposes it behaves as a combinational unit. Each of its two read ports returns the word at its address in the same cycle, with no register stage in the read path.

The single write port is driven by an elastic channel. The controller's raw write request counts only when that channel carries a token (valid high) and the token is being accepted (stop low). An active write request that arrives with a bubble, or with a token that is being retried, therefore leaves every stored word untouched. The stop wire seen by the write-channel sender is the downstream consumer's stop, passed straight through, so the file never adds a stall of its own.

Entry zero is hard-wired to zero. A read of an entry that is being written in the same cycle returns the contents from before the write.

Top module: `vq_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads as zero until it is written.
- R2: Each read port is combinational: when its address changes, its data shows the addressed entry within the same clock cycle.
- R3: On a rising clock edge where wr_req=1, wch_valid=1 and sink_stop=0, the entry at wr_sel takes wr_word, provided wr_sel is not zero.
- R4: When wr_req=1 and wch_valid=0, no entry changes, whatever wr_word holds.
- R5: When wr_req=1, wch_valid=1 and sink_stop=1 (a retry), no entry changes. A token that is retried and then accepted is written once.
- R6: Address 0 always reads 0x00 on both ports, and writes to it have no effect.
- R7: A read of the address being written returns the old value during the writing cycle and the new value from the next cycle on.
- R8: wch_stop equals sink_stop in every cycle. The file never raises stop itself.
- R9: When wr_req=0, no entry changes, even with a valid, accepted token on the channel.
- R10: The two read ports are independent and may address the same entry or different entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| rd_sel_a | input | 3 | Read port A address |
| rd_val_a | output | 8 | Read port A data, combinational |
| rd_sel_b | input | 3 | Read port B address |
| rd_val_b | output | 8 | Read port B data, combinational |
| wr_req | input | 1 | Raw write request from the controller |
| wr_sel | input | 3 | Write address |
| wr_word | input | 8 | Write data |
| wch_valid | input | 1 | Write channel valid (token present) |
| sink_stop | input | 1 | Stop from the downstream consumer |
| wch_stop | output | 1 | Stop returned to the write-channel sender |

## Verification
Two functions meet in one cycle when the write and a read both target the same entry. The bench provokes this by presenting a committed write with both read ports on the write address. It judges the read data after the inputs settle and before the edge (it must be the old word), and again in the following cycle (it must be the new word). A second collision comes from pairing an active write request with a bubble or a retry while a read watches the target. The bench judges it by confirming that the read stays at its previous value across the edge and in later cycles.

// File: rtl/vq_regfile.sv
module vq_regfile #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_sel_a,
  output logic [WIDTH-1:0] rd_val_a,
  input  logic [AW-1:0]    rd_sel_b,
  output logic [WIDTH-1:0] rd_val_b,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_sel,
  input  logic [WIDTH-1:0] wr_word,
  input  logic             wch_valid,
  input  logic             sink_stop,
  output logic             wch_stop
);

  logic             commit;
  logic [WIDTH-1:0] cells [ENTRIES];

  assign commit   = wr_req & wch_valid & ~sink_stop;
  assign wch_stop = sink_stop;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cell
    if (i == 0) begin : g_zero
      assign cells[i] = '0;
    end else begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (commit && wr_sel == AW'(i))
          q <= wr_word;
      end
      assign cells[i] = q;
    end
  end

  assign rd_val_a = cells[rd_sel_a];
  assign rd_val_b = cells[rd_sel_b];

endmodule

// File: rtl/vq_regfile_chk.sv
module vq_regfile_chk #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  localparam int AW     = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    rd_sel_a,
  input logic [WIDTH-1:0] rd_val_a,
  input logic [AW-1:0]    rd_sel_b,
  input logic [WIDTH-1:0] rd_val_b,
  input logic             wr_req,
  input logic [AW-1:0]    wr_sel,
  input logic [WIDTH-1:0] wr_word,
  input logic             wch_valid,
  input logic             sink_stop
);

  p_zero_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == '0) |-> (rd_val_a == '0));

  p_commit_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wch_valid && !sink_stop && wr_sel != '0 && rd_sel_b == wr_sel)
    |=> (rd_sel_b != $past(wr_sel) || rd_val_b == $past(wr_word)));

  p_bubble_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wch_valid) |=> (rd_sel_a != $past(rd_sel_a) || rd_val_a == $past(rd_val_a)));

  p_retry_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wch_valid && sink_stop) |=> (rd_sel_a != $past(rd_sel_a) || rd_val_a == $past(rd_val_a)));

  p_no_request_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_req) |=> (rd_sel_b != $past(rd_sel_b) || rd_val_b == $past(rd_val_b)));

endmodule

bind vq_regfile vq_regfile_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_sel_a(rd_sel_a), .rd_val_a(rd_val_a),
  .rd_sel_b(rd_sel_b), .rd_val_b(rd_val_b),
  .wr_req(wr_req), .wr_sel(wr_sel), .wr_word(wr_word),
  .wch_valid(wch_valid), .sink_stop(sink_stop)
);

// File: tb/vq_regfile_test.sv
module vq_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rd_sel_a = '0, rd_sel_b = '0, wr_sel = '0;
  logic [7:0] rd_val_a, rd_val_b, wr_word = '0;
  logic       wr_req = 1'b0, wch_valid = 1'b0, sink_stop = 1'b0, wch_stop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vq_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .rd_sel_a(rd_sel_a), .rd_val_a(rd_val_a),
    .rd_sel_b(rd_sel_b), .rd_val_b(rd_val_b),
    .wr_req(wr_req), .wr_sel(wr_sel), .wr_word(wr_word),
    .wch_valid(wch_valid), .sink_stop(sink_stop), .wch_stop(wch_stop)
  );

  // {tag[3:0], req, valid, stop, wsel[2:0], word[7:0], sel_a[2:0], sel_b[2:0], exp_a[7:0], exp_b[7:0]}
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {4'd1,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd1,3'd2,8'h00,8'h00}, // R1
    {4'd7,  1'b1,1'b1,1'b0,3'd1,8'hA5,3'd1,3'd1,8'h00,8'h00}, // R7 old value
    {4'd3,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd1,3'd0,8'hA5,8'h00}, // R3
    {4'd4,  1'b1,1'b0,1'b0,3'd1,8'hFF,3'd1,3'd1,8'hA5,8'hA5}, // R4 bubble
    {4'd4,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd1,3'd1,8'hA5,8'hA5}, // R4
    {4'd5,  1'b1,1'b1,1'b1,3'd2,8'h3C,3'd2,3'd2,8'h00,8'h00}, // R5 retry
    {4'd5,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd2,3'd1,8'h00,8'hA5}, // R5
    {4'd9,  1'b0,1'b1,1'b0,3'd3,8'h77,3'd3,3'd3,8'h00,8'h00}, // R9
    {4'd9,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd3,3'd3,8'h00,8'h00}, // R9
    {4'd6,  1'b1,1'b1,1'b0,3'd0,8'h99,3'd0,3'd0,8'h00,8'h00}, // R6
    {4'd6,  1'b0,1'b0,1'b0,3'd0,8'h00,3'd0,3'd1,8'h00,8'hA5}, // R6
    {4'd7,  1'b1,1'b1,1'b0,3'd7,8'h5A,3'd1,3'd7,8'hA5,8'h00}, // R7
    {4'd10, 1'b0,1'b0,1'b0,3'd0,8'h00,3'd7,3'd1,8'h5A,8'hA5}, // R10
    {4'd7,  1'b1,1'b1,1'b0,3'd1,8'h11,3'd1,3'd7,8'hA5,8'h5A}, // R7
    {4'd10, 1'b0,1'b0,1'b0,3'd0,8'h00,3'd7,3'd1,8'h5A,8'h11}  // R10
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: contents during reset
    repeat (2) @(negedge clk);
    rd_sel_a = 3'd5; rd_sel_b = 3'd7;
    #1;
    check("R1", rd_val_a, 8'h00);
    check("R1", rd_val_b, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_req    = VEC[i][35];
      wch_valid = VEC[i][34];
      sink_stop = VEC[i][33];
      wr_sel    = VEC[i][32:30];
      wr_word   = VEC[i][29:22];
      rd_sel_a  = VEC[i][21:19];
      rd_sel_b  = VEC[i][18:16];
      #1;
      check($sformatf("R%0d vec%0d port a", VEC[i][39:36], i), rd_val_a, VEC[i][15:8]);
      check($sformatf("R%0d vec%0d port b", VEC[i][39:36], i), rd_val_b, VEC[i][7:0]);
    end

    // R5: retry for two cycles, then accept the same token; written once
    @(negedge clk);
    wr_req = 1'b1; wch_valid = 1'b1; sink_stop = 1'b1; wr_sel = 3'd4; wr_word = 8'hC3;
    rd_sel_a = 3'd4;
    @(negedge clk);
    #1 check("R5 retry cycle", rd_val_a, 8'h00);
    @(negedge clk);
    sink_stop = 1'b0;
    #1 check("R5 accept cycle", rd_val_a, 8'h00);
    @(negedge clk);
    wr_req = 1'b0; wch_valid = 1'b0;
    #1 check("R5 after accept", rd_val_a, 8'hC3);

    // R2: address change shows data within the same cycle, no edge between
    @(negedge clk);
    rd_sel_a = 3'd7;
    #1 check("R2 sel 7", rd_val_a, 8'h5A);
    rd_sel_a = 3'd1;
    #1 check("R2 sel 1", rd_val_a, 8'h11);

    // R8: stop passes straight through
    sink_stop = 1'b1;
    #1 check("R8 high", {7'd0, wch_stop}, 8'h01);
    sink_stop = 1'b0;
    #1 check("R8 low", {7'd0, wch_stop}, 8'h00);

    // R1: reset clears written entries
    @(negedge clk);
    rst_n = 1'b0;
    rd_sel_a = 3'd1; rd_sel_b = 3'd7;
    #1;
    check("R1 reclear a", rd_val_a, 8'h00);
    check("R1 reclear b", rd_val_b, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 after release", rd_val_a, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule